// File: doc/BRIEF.md
# Slot-Switched Multi-Generator Stream Cipher

This block encrypts or decrypts a bit-serial data stream by XORing each data bit with a keystream bit. The keystream does not come from a single shift register. Five independent 16-bit Galois LFSRs run side by side, and a sixth LFSR, the slot controller, picks which one supplies the current keystream bit. Every generator steps on every accepted data bit, whether or not it is selected. When the controller returns to a generator, that generator therefore resumes from a different point in its sequence.

A start pulse puts every register into a fixed initial state. Two instances that see the same start and the same accepted bits produce the same keystream, so one instance encrypts and a second, fed with the ciphertext, recovers the plaintext. At regular intervals a rekey event XORs each generator's next state with that generator's own key constant. The LFSRs, the control sequence and the rekey timer advance only on cycles where the data-valid strobe is high.

Top module: `msc_stream_cipher`

## Requirements
- R1: After reset the output is 0. Every generator then holds its seed, the controller holds seed 16'h7B13, and the bit counters are zero.
- R2: On a cycle with valid high and start low, the registered output takes din XOR the selected keystream bit one clock later.
- R3: On a cycle with valid and start both low, no register advances and the output holds its value.
- R4: On each accepted bit, every generator steps by s' = (s >> 1) XOR (s[0] ? mask : 0), selected or not. The generator's keystream bit is s[0] of the state before the step. The masks for generators 0..4 are B400, D008, 9C00, E801, 8805 (hex). The seeds are ACE1, 1D2B, 5E7F, 9340, C3A5.
- R5: The controller selects generator ctrl[2:0] mod 5. It steps with mask 16'hA011 once every DWELL accepted bits (default 8), so each selection lasts DWELL bits.
- R6: On the RELOAD-th accepted bit after a start (default 1024), and on every RELOAD-th bit after that, each generator's next state is its stepped state XOR its key. The keys for generators 0..4 are 3C5A, 0F0F, A5A5, 1234, 6C93 (hex).
- R7: No generator state is ever all-zero. A zero result is replaced by that generator's seed.
- R8: A start pulse has priority over valid. It discards that cycle's data bit, clears the output to 0 and restores the R1 state.
- R9: Feeding the ciphertext back after a new start reproduces the plaintext bit for bit.
- R10: The keystream bit is gated by a one-hot slot enable that has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data bit clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Synchronising pulse that loads all seeds |
| din_vld | input | 1 | Marks a cycle that carries a data bit |
| din | input | 1 | Serial plaintext or ciphertext bit |
| dout | output | 1 | Registered serial result bit |

## Verification
A wrong generator state, mask, selection or dwell count corrupts the keystream. It appears at dout on the next accepted bit that draws from the affected generator, which is at most a few dwell periods later. A fault in the rekey path remains hidden until the first rekey event, at accepted bit 1024. After that the output diverges within a few bits, so the stimulus runs well past that point. Idle cycles expose any register that advances without valid, because every later output bit is then shifted against the reference.

// File: rtl/msc_pkg.sv
package msc_pkg;
    localparam int LFSR_W  = 16;
    localparam int NUM_GEN = 5;
    localparam int SEL_W   = $clog2(NUM_GEN);

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef struct packed {
        lfsr_t mask;
        lfsr_t seed;
        lfsr_t key;
    } gen_cfg_t;

    localparam lfsr_t CTRL_MASK = 16'hA011;
    localparam lfsr_t CTRL_SEED = 16'h7B13;

    function automatic gen_cfg_t gen_cfg(input int idx);
        gen_cfg_t c;
        case (idx)
            0:       c = '{mask: 16'hB400, seed: 16'hACE1, key: 16'h3C5A};
            1:       c = '{mask: 16'hD008, seed: 16'h1D2B, key: 16'h0F0F};
            2:       c = '{mask: 16'h9C00, seed: 16'h5E7F, key: 16'hA5A5};
            3:       c = '{mask: 16'hE801, seed: 16'h9340, key: 16'h1234};
            default: c = '{mask: 16'h8805, seed: 16'hC3A5, key: 16'h6C93};
        endcase
        return c;
    endfunction

    function automatic lfsr_t lfsr_next(input lfsr_t s, input lfsr_t mask);
        return {1'b0, s[LFSR_W-1:1]} ^ (s[0] ? mask : '0);
    endfunction

    function automatic lfsr_t force_nz(input lfsr_t s, input lfsr_t seed);
        return (s == '0) ? seed : s;
    endfunction
endpackage

// File: rtl/msc_keygen.sv
module msc_keygen
    import msc_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic step_en,
    input  logic rekey,
    output logic key_bit
);
    localparam gen_cfg_t CFG = gen_cfg(IDX);

    lfsr_t st_q;
    lfsr_t st_step;
    lfsr_t st_d;

    always_comb begin
        st_step = lfsr_next(st_q, CFG.mask);
        st_d    = force_nz(rekey ? (st_step ^ CFG.key) : st_step, CFG.seed);
    end

    always_ff @(posedge clk) begin
        if (rst || start)
            st_q <= CFG.seed;
        else if (step_en)
            st_q <= st_d;
    end

    assign key_bit = st_q[0];

    // R7: state never zero
    assert_state_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        st_q != '0);
    // R1, R8: start restores seed
    assert_start_seed_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> st_q == CFG.seed);
    // R3: idle holds state
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!start && !step_en) |=> $stable(st_q));
endmodule

// File: rtl/msc_slot_ctrl.sv
module msc_slot_ctrl
    import msc_pkg::*;
#(
    parameter int DWELL = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               step_en,
    output logic [NUM_GEN-1:0] slot_en
);
    localparam int DW_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL - 1);

    lfsr_t           ctrl_q;
    logic [DW_W-1:0] dw_q;
    logic            dw_wrap;
    int              sel_idx;

    assign dw_wrap = step_en && (dw_q == DW_LAST);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            ctrl_q <= CTRL_SEED;
            dw_q   <= '0;
        end else if (step_en) begin
            if (dw_q == DW_LAST) begin
                dw_q   <= '0;
                ctrl_q <= force_nz(lfsr_next(ctrl_q, CTRL_MASK), CTRL_SEED);
            end else begin
                dw_q <= dw_q + 1'b1;
            end
        end
    end

    always_comb begin
        sel_idx = int'(ctrl_q[SEL_W-1:0]) % NUM_GEN;
        for (int i = 0; i < NUM_GEN; i++)
            slot_en[i] = (sel_idx == i);
    end

    // R10: exactly one slot enabled
    assert_slot_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(slot_en) == 1);
    // R5: control only moves at dwell boundary
    assert_dwell_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!start && !dw_wrap) |=> $stable(ctrl_q));
    // R5: dwell counter bounded
    assert_dwell_range_R5: assert property (@(posedge clk) disable iff (rst)
        dw_q <= DW_LAST);
endmodule

// File: rtl/msc_rekey_timer.sv
module msc_rekey_timer #(
    parameter int RELOAD = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic step_en,
    output logic rekey
);
    localparam int CW = (RELOAD > 1) ? $clog2(RELOAD) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RELOAD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || start)
            cnt_q <= '0;
        else if (step_en)
            cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end

    assign rekey = step_en && (cnt_q == CNT_LAST);

    // R6: counter bounded and restarts after a rekey
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST);
    assert_cnt_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (rekey && !start) |=> cnt_q == '0);
endmodule

// File: rtl/msc_stream_cipher.sv
module msc_stream_cipher
    import msc_pkg::*;
#(
    parameter int DWELL  = 8,
    parameter int RELOAD = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic din_vld,
    input  logic din,
    output logic dout
);
    logic               step_en;
    logic               rekey;
    logic [NUM_GEN-1:0] slot_en;
    logic [NUM_GEN-1:0] gen_bit;
    logic               ks_bit;
    logic               dout_q;

    assign step_en = din_vld && !start;

    msc_slot_ctrl #(.DWELL(DWELL)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .step_en(step_en), .slot_en(slot_en)
    );

    msc_rekey_timer #(.RELOAD(RELOAD)) u_rekey (
        .clk(clk), .rst(rst), .start(start), .step_en(step_en), .rekey(rekey)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        msc_keygen #(.IDX(g)) u_gen (
            .clk(clk), .rst(rst), .start(start), .step_en(step_en),
            .rekey(rekey), .key_bit(gen_bit[g])
        );
    end

    assign ks_bit = |(gen_bit & slot_en);

    always_ff @(posedge clk) begin
        if (rst || start)
            dout_q <= 1'b0;
        else if (step_en)
            dout_q <= din ^ ks_bit;
    end

    assign dout = dout_q;

    // R3: output holds on idle cycles
    assert_dout_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!start && !din_vld) |=> $stable(dout));
    // R8: start clears output
    assert_start_clear_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> !dout);
endmodule

// File: tb/msc_stream_cipher_tb.sv
module msc_stream_cipher_tb;
    localparam int DWELL  = 8;
    localparam int RELOAD = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic din_vld = 1'b0;
    logic din = 1'b0;
    logic dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    msc_stream_cipher #(.DWELL(DWELL), .RELOAD(RELOAD)) u_dut (
        .clk(clk), .rst(rst), .start(start), .din_vld(din_vld), .din(din), .dout(dout)
    );

    // reference model, built from the requirements
    logic [15:0] m_g [5];
    logic [15:0] m_c;
    int          m_dw;
    int          m_rc;
    logic        m_dout;

    function automatic logic [15:0] r_mask(int i);
        case (i) 0: return 16'hB400; 1: return 16'hD008; 2: return 16'h9C00;
                 3: return 16'hE801; default: return 16'h8805; endcase
    endfunction
    function automatic logic [15:0] r_seed(int i);
        case (i) 0: return 16'hACE1; 1: return 16'h1D2B; 2: return 16'h5E7F;
                 3: return 16'h9340; default: return 16'hC3A5; endcase
    endfunction
    function automatic logic [15:0] r_key(int i);
        case (i) 0: return 16'h3C5A; 1: return 16'h0F0F; 2: return 16'hA5A5;
                 3: return 16'h1234; default: return 16'h6C93; endcase
    endfunction
    function automatic logic [15:0] r_step(logic [15:0] s, logic [15:0] m);
        return (s >> 1) ^ (s[0] ? m : 16'h0);
    endfunction

    function automatic void model_start();
        for (int i = 0; i < 5; i++) m_g[i] = r_seed(i);
        m_c = 16'h7B13; m_dw = 0; m_rc = 0; m_dout = 1'b0;
    endfunction

    function automatic void model_bit(logic d);
        int sel;
        logic [15:0] t;
        sel = int'(m_c[2:0]) % 5;
        m_dout = d ^ m_g[sel][0];
        for (int i = 0; i < 5; i++) begin
            t = r_step(m_g[i], r_mask(i));
            if (m_rc == RELOAD - 1) t = t ^ r_key(i);
            m_g[i] = (t == 16'h0) ? r_seed(i) : t;
        end
        m_rc = (m_rc == RELOAD - 1) ? 0 : m_rc + 1;
        if (m_dw == DWELL - 1) begin
            m_dw = 0;
            m_c = r_step(m_c, 16'hA011);
        end else m_dw++;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dout=%0b expected %0b", tag, act, exp);
        end
    endtask

    // inputs driven at negedge, output sampled 1 ns after posedge
    task automatic cycle(logic s, logic v, logic d);
        start = s; din_vld = v; din = d;
        @(posedge clk); #1;
        @(negedge clk);
    endtask

    task automatic do_start();
        cycle(1'b1, 1'b0, 1'b0);
        model_start();
        check("R8 start clears", dout, 1'b0);
    endtask

    task automatic send(string tag, logic d);
        start = 1'b0; din_vld = 1'b1; din = d;
        @(posedge clk); #1;
        model_bit(d);
        check(tag, dout, m_dout);
        @(negedge clk);
    endtask

    task automatic idle();
        start = 1'b0; din_vld = 1'b0; din = $urandom_range(0, 1);
        @(posedge clk); #1;
        check("R3 idle hold", dout, m_dout);
        @(negedge clk);
    endtask

    logic plain [400];
    logic ciph  [400];

    initial begin
        void'($urandom(32'd20240611));
        model_start();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset output", dout, 1'b0);

        // R1: first bits straight after reset without start use seed state
        for (int n = 0; n < 20; n++) send("R1 R2 post-reset", 1'b0);

        // R8: start with valid high discards the bit
        cycle(1'b1, 1'b1, 1'b1);
        model_start();
        check("R8 start priority", dout, 1'b0);

        // directed: all-zero plaintext exposes raw keystream
        for (int n = 0; n < 64; n++) send("R4 R5 R10 zeros", 1'b0);
        do_start();
        for (int n = 0; n < 64; n++) send("R2 ones", 1'b1);

        // random long run crossing two rekey events, with idle gaps
        do_start();
        for (int n = 0; n < 2300; n++) begin
            if ($urandom_range(0, 3) == 0) idle();
            if (n >= RELOAD - 4 && n < RELOAD + 40)
                send("R6 R7 rekey window", 1'($urandom_range(0, 1)));
            else
                send("R4 R5 R10 random", 1'($urandom_range(0, 1)));
        end

        // R9: encrypt, restart, decrypt
        do_start();
        for (int n = 0; n < 400; n++) begin
            plain[n] = 1'($urandom_range(0, 1));
            send("R2 encrypt", plain[n]);
            ciph[n] = dout;
            if ($urandom_range(0, 4) == 0) idle();
        end
        do_start();
        for (int n = 0; n < 400; n++) begin
            send("R9 model", ciph[n]);
            check("R9 decrypt", dout, plain[n]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule